// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit down-counting channel of an interval timer. A host writes a count value together with a mode code and a counting radix (binary or four-digit decimal). The counter advances only on cycles where the timer clock enable `tick` is high. The `gate_in` input either pauses the count or starts it, depending on the mode. The channel produces one output waveform, `out_pin`, and shows its live count on `count_out`.

Six behaviours are offered: an interrupt-style terminal-count flag, a gate-started one-shot that can be restarted, a periodic rate generator, a square wave, a strobe started by the write, and a strobe started by the gate. A written value of zero selects the longest period the radix allows. The write itself never moves the counter. The value is moved into the counter on the first tick after the write, or on the first tick after a gate trigger in the gate-started modes.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out_pin` is 1 and `count_out` is 0, and ticks change neither until a count is written.
- R2: A write (`wr_stb`, with mode `mode_sel`, radix `bcd_sel` and value `wr_val` all sampled in that cycle) leaves `count_out` unchanged. The value appears on `count_out` after the next cycle in which `tick` is high. `count_out` changes only after cycles with `tick` high.
- R3: Mode code 0: `out_pin` goes low in the cycle after the write. Each tick with `gate_in` high decrements the count. `out_pin` goes high when the count reaches 0, which is N ticks after the load tick, and then stays high while the counter keeps wrapping. A tick with `gate_in` low leaves both count and output unchanged.
- R4: Mode code 1: after the write, `out_pin` stays high and nothing is loaded until a rising edge on `gate_in`. The next tick loads N and drives `out_pin` low. `out_pin` goes high when the count reaches 0. A later rising edge reloads N on the next tick and drives `out_pin` low again.
- R5: Mode codes 2 and 6 (rate generator): the load tick shows N with `out_pin` high. `out_pin` is low for exactly one tick once the count reaches 1. The following tick reloads N with `out_pin` high, so the period is N ticks.
- R6: Mode codes 3 and 7 (square wave): the count steps down by 2 and always reads even. The load value is N with bit 0 cleared. `out_pin` is high for (N+1)/2 ticks (rounded down) and low for the remaining ticks of each N-tick period.
- R7: In the rate-generator and square-wave modes, `gate_in` low forces `out_pin` high in the same cycle and freezes the count. A rising edge on `gate_in` reloads the count on the next tick and restarts the period with `out_pin` high.
- R8: Mode code 4: `out_pin` stays high and the count decrements on ticks with `gate_in` high. `out_pin` goes low for exactly one tick when the count first reaches 0, and does not pulse again.
- R9: Mode code 5: the count waits for a rising edge on `gate_in` with `out_pin` high. The next tick loads N. After N further ticks the count reaches 0 and `out_pin` pulses low for one tick.
- R10: A written value of 0 counts as 65536 ticks in binary (`bcd_sel`=0) and as 10000 ticks in decimal (`bcd_sel`=1).
- R11: In decimal mode each 4-bit nibble is one decimal digit, borrows pass between digits, and 0000 wraps to 9999. In binary mode 0000 wraps to FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Timer clock enable; one count step per high cycle |
| gate_in | input | 1 | Gate: pauses or triggers, depending on the mode |
| mode_sel | input | 3 | Mode code, sampled on write |
| bcd_sel | input | 1 | 1 = decimal counting, 0 = binary; sampled on write |
| wr_stb | input | 1 | Count write strobe |
| wr_val | input | 16 | Count value to write |
| count_out | output | 16 | Current counter contents |
| out_pin | output | 1 | Channel output waveform |

## Verification
Each mode runs with small counts of 2 to 5 so that every tick of the waveform and every counter value can be predicted. The square wave uses both an odd and an even count, which separates correct odd-count duty handling from a plain halving of the period. Gate-low windows are placed mid-count and during a low output phase, which separates pausing from ignoring the gate and shows that the output is forced high at once. A retrigger, decimal borrow and wrap values, and the two full-range zero counts measured tick by tick show whether the radix and the load timing are right.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_INTR    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTRB  = 3'd4,
    M_HWSTRB  = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2,
    ST_RUN  = 2'd3
  } state_e;

  // codes 6 and 7 alias the two periodic modes
  function automatic mode_e norm_mode(input logic [2:0] code);
    case (code)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return mode_e'(code);
    endcase
  endfunction

  function automatic logic gate_started(input mode_e m);
    return (m == M_ONESHOT) || (m == M_HWSTRB);
  endfunction

endpackage

// File: rtl/pit_rst_sync.sv
module pit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  input  logic tick,
  input  logic clr,
  output logic trig
);
  logic gate_q;
  logic pend_q, pend_n;
  logic rise;

  assign rise = gate_in & ~gate_q;
  assign trig = pend_q | rise;

  always_comb begin
    pend_n = pend_q;
    if (clr)       pend_n = 1'b0;
    else if (tick) pend_n = 1'b0;
    else if (rise) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gate_q <= gate_in;
      pend_q <= pend_n;
    end
  end
endmodule

// File: rtl/pit_decr.sv
module pit_decr #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] val,
  input  logic             bcd,
  input  logic             step2,
  output logic [CNT_W-1:0] res
);
  localparam int DIGITS = CNT_W / 4;

  logic [DIGITS-1:0][1:0] bor;
  logic [CNT_W-1:0]       bcd_res;
  logic [CNT_W-1:0]       bin_res;

  assign bor[0]  = step2 ? 2'd2 : 2'd1;
  assign bin_res = val - {{(CNT_W-2){1'b0}}, bor[0]};

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [4:0] diff;
    assign diff = {1'b0, val[4*g +: 4]} - {3'b000, bor[g]};
    assign bcd_res[4*g +: 4] = diff[4] ? (diff[3:0] + 4'd10) : diff[3:0];
    if (g < DIGITS - 1) begin : g_chain
      assign bor[g+1] = {1'b0, diff[4]};
    end
  end

  assign res = bcd ? bcd_res : bin_res;
endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate_in,
  input  logic             trig,
  input  logic             wr_stb,
  input  logic [2:0]       mode_sel,
  input  logic             bcd_sel,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] dec,
  output logic [CNT_W-1:0] cnt,
  output logic             out_q_o,
  output logic             bcd_o,
  output logic             step2_o,
  output mode_e            mode_o,
  output state_e           state_o
);
  state_e           state_q, state_n;
  mode_e            mode_q,  mode_n;
  logic             bcd_q,   bcd_n;
  logic [CNT_W-1:0] rld_q,   rld_n;
  logic [CNT_W-1:0] cnt_q,   cnt_n;
  logic             out_q,   out_n;
  logic             extra_q, extra_n;
  logic             done_q,  done_n;

  logic [CNT_W-1:0] rld_even;
  logic             dec_zero, dec_one, cnt_one;
  mode_e            wr_mode;

  assign rld_even = {rld_q[CNT_W-1:1], 1'b0};
  assign dec_zero = (dec == '0);
  assign dec_one  = (dec == CNT_W'(1));
  assign cnt_one  = (cnt_q == CNT_W'(1));
  assign wr_mode  = norm_mode(mode_sel);

  always_comb begin
    state_n = state_q;
    mode_n  = mode_q;
    bcd_n   = bcd_q;
    rld_n   = rld_q;
    cnt_n   = cnt_q;
    out_n   = out_q;
    extra_n = extra_q;
    done_n  = done_q;
    if (wr_stb) begin
      mode_n  = wr_mode;
      bcd_n   = bcd_sel;
      rld_n   = wr_val;
      extra_n = 1'b0;
      done_n  = 1'b0;
      state_n = gate_started(wr_mode) ? ST_WAIT : ST_LOAD;
      out_n   = (wr_mode != M_INTR);
    end else if (tick) begin
      case (state_q)
        ST_LOAD: begin
          state_n = ST_RUN;
          out_n   = 1'b1;
          case (mode_q)
            M_INTR: begin
              cnt_n = rld_q;
              out_n = 1'b0;
            end
            M_SQUARE: begin
              cnt_n   = rld_even;
              extra_n = rld_q[0];
            end
            default: cnt_n = rld_q;
          endcase
        end
        ST_WAIT: begin
          if (trig) begin
            state_n = ST_RUN;
            cnt_n   = rld_q;
            done_n  = 1'b0;
            out_n   = (mode_q != M_ONESHOT);
          end
        end
        ST_RUN: begin
          case (mode_q)
            M_INTR: begin
              if (gate_in) begin
                cnt_n = dec;
                if (dec_zero) out_n = 1'b1;
              end
            end
            M_ONESHOT: begin
              if (trig) begin
                cnt_n = rld_q;
                out_n = 1'b0;
              end else begin
                cnt_n = dec;
                if (dec_zero) out_n = 1'b1;
              end
            end
            M_RATE: begin
              if (trig) begin
                cnt_n = rld_q;
                out_n = 1'b1;
              end else if (gate_in) begin
                if (cnt_one) begin
                  cnt_n = rld_q;
                  out_n = 1'b1;
                end else begin
                  cnt_n = dec;
                  out_n = !dec_one;
                end
              end
            end
            M_SQUARE: begin
              if (trig) begin
                cnt_n   = rld_even;
                out_n   = 1'b1;
                extra_n = rld_q[0];
              end else if (gate_in) begin
                if (extra_q) begin
                  extra_n = 1'b0;
                end else if (dec_zero) begin
                  out_n   = !out_q;
                  cnt_n   = rld_even;
                  extra_n = !out_q & rld_q[0];
                end else begin
                  cnt_n = dec;
                end
              end
            end
            M_SWSTRB: begin
              if (gate_in) begin
                cnt_n = dec;
                out_n = !(dec_zero && !done_q);
                if (dec_zero) done_n = 1'b1;
              end
            end
            M_HWSTRB: begin
              if (trig) begin
                cnt_n  = rld_q;
                out_n  = 1'b1;
                done_n = 1'b0;
              end else begin
                cnt_n = dec;
                out_n = !(dec_zero && !done_q);
                if (dec_zero) done_n = 1'b1;
              end
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= M_INTR;
      bcd_q   <= 1'b0;
      rld_q   <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b1;
      extra_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      mode_q  <= mode_n;
      bcd_q   <= bcd_n;
      rld_q   <= rld_n;
      cnt_q   <= cnt_n;
      out_q   <= out_n;
      extra_q <= extra_n;
      done_q  <= done_n;
    end
  end

  assign cnt     = cnt_q;
  assign out_q_o = out_q;
  assign bcd_o   = bcd_q;
  assign step2_o = (mode_q == M_SQUARE);
  assign mode_o  = mode_q;
  assign state_o = state_q;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate_in,
  input  logic [2:0]       mode_sel,
  input  logic             bcd_sel,
  input  logic             wr_stb,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] count_out,
  output logic             out_pin
);
  logic             rst_sync_n;
  logic             trig;
  logic [CNT_W-1:0] dec;
  logic             out_q;
  logic             bcd_cur;
  logic             step2;
  mode_e            cur_mode;
  state_e           cur_state;
  logic             gate_force;

  pit_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pit_gate_edge edge_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .gate_in (gate_in),
    .tick    (tick),
    .clr     (wr_stb),
    .trig    (trig)
  );

  pit_decr #(.CNT_W(CNT_W)) decr_i (
    .val   (count_out),
    .bcd   (bcd_cur),
    .step2 (step2),
    .res   (dec)
  );

  pit_core #(.CNT_W(CNT_W)) core_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .gate_in  (gate_in),
    .trig     (trig),
    .wr_stb   (wr_stb),
    .mode_sel (mode_sel),
    .bcd_sel  (bcd_sel),
    .wr_val   (wr_val),
    .dec      (dec),
    .cnt      (count_out),
    .out_q_o  (out_q),
    .bcd_o    (bcd_cur),
    .step2_o  (step2),
    .mode_o   (cur_mode),
    .state_o  (cur_state)
  );

  assign gate_force = (cur_state == ST_RUN) && !gate_in &&
                      ((cur_mode == M_RATE) || (cur_mode == M_SQUARE));
  assign out_pin    = out_q | gate_force;
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_stb,
  input logic             gate_in,
  input logic             out_pin,
  input logic [CNT_W-1:0] count_out,
  input mode_e            cur_mode,
  input state_e           cur_state
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_IDLE) |-> (out_pin && count_out == '0)); // R1

  AST_COUNT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_out)); // R2

  AST_WAIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_WAIT) |-> out_pin); // R4

  AST_RATE_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_RUN && cur_mode == M_RATE && !out_pin && tick &&
     gate_in && !wr_stb) |=> out_pin); // R5

  AST_SQUARE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_RUN && cur_mode == M_SQUARE) |-> !count_out[0]); // R6

  AST_GATE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_RUN && !gate_in &&
     (cur_mode == M_RATE || cur_mode == M_SQUARE)) |-> out_pin); // R7

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_RUN && (cur_mode == M_SWSTRB || cur_mode == M_HWSTRB) &&
     !out_pin && tick && gate_in && !wr_stb) |=> out_pin); // R8
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_stb    (wr_stb),
  .gate_in   (gate_in),
  .out_pin   (out_pin),
  .count_out (count_out),
  .cur_mode  (cur_mode),
  .cur_state (cur_state)
);

// File: tb/pit_channel_tb_top.sv
module pit_channel_tb_top;
  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        gate_in;
  logic [2:0]  mode_sel;
  logic        bcd_sel;
  logic        wr_stb;
  logic [15:0] wr_val;
  logic [15:0] count_out;
  logic        out_pin;

  int checks = 0;
  int errors = 0;
  logic tick_d = 1'b0;

  typedef struct {
    logic        o;
    logic [15:0] c;
    logic        cc;
    string       r;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  pit_channel dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .gate_in   (gate_in),
    .mode_sel  (mode_sel),
    .bcd_sel   (bcd_sel),
    .wr_stb    (wr_stb),
    .wr_val    (wr_val),
    .count_out (count_out),
    .out_pin   (out_pin)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) tick_d <= tick;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares one queued item after every tick
  always @(negedge clk) begin
    if (tick_d && exp_q.size() != 0) begin
      cur = exp_q.pop_front();
      chk({15'd0, out_pin}, {15'd0, cur.o}, {cur.r, " out_pin"});
      if (cur.cc) chk(count_out, cur.c, {cur.r, " count_out"});
    end
  end

  task automatic tick_exp(input logic eo, input logic [15:0] ec, input logic cc, input string req);
    exp_t e;
    e.o = eo; e.c = ec; e.cc = cc; e.r = req;
    exp_q.push_back(e);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] m, input logic b, input logic [15:0] v);
    mode_sel = m; bcd_sel = b; wr_val = v; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic set_gate(input logic v);
    gate_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; gate_in = 1'b1; mode_sel = '0;
    bcd_sel = 1'b0; wr_stb = 1'b0; wr_val = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, ticks without a write
    chk({15'd0, out_pin}, 16'd1, "R1 out");
    chk(count_out, 16'd0, "R1 count");
    tick_exp(1'b1, 16'd0, 1'b1, "R1");
    tick_exp(1'b1, 16'd0, 1'b1, "R1");

    // R2/R3: mode 0, binary, count 3
    wr(3'd0, 1'b0, 16'd3);
    chk({15'd0, out_pin}, 16'd0, "R3 out after write");
    chk(count_out, 16'd0, "R2 count before load");
    tick_exp(1'b0, 16'd3, 1'b1, "R2");
    tick_exp(1'b0, 16'd2, 1'b1, "R3");
    tick_exp(1'b0, 16'd1, 1'b1, "R3");
    tick_exp(1'b1, 16'd0, 1'b1, "R3");
    tick_exp(1'b1, 16'hFFFF, 1'b1, "R11");
    tick_exp(1'b1, 16'hFFFE, 1'b1, "R3");

    // R3: gate low pauses mode 0
    wr(3'd0, 1'b0, 16'd3);
    tick_exp(1'b0, 16'd3, 1'b1, "R3");
    set_gate(1'b0);
    tick_exp(1'b0, 16'd3, 1'b1, "R3 paused");
    tick_exp(1'b0, 16'd3, 1'b1, "R3 paused");
    set_gate(1'b1);
    tick_exp(1'b0, 16'd2, 1'b1, "R3");
    tick_exp(1'b0, 16'd1, 1'b1, "R3");
    tick_exp(1'b1, 16'd0, 1'b1, "R3");

    // R4: gate-started one-shot with retrigger
    set_gate(1'b0);
    wr(3'd1, 1'b0, 16'd2);
    chk({15'd0, out_pin}, 16'd1, "R4 out waiting");
    tick_exp(1'b1, 16'd0, 1'b0, "R4 waiting");
    set_gate(1'b1);
    tick_exp(1'b0, 16'd2, 1'b1, "R4");
    tick_exp(1'b0, 16'd1, 1'b1, "R4");
    tick_exp(1'b1, 16'd0, 1'b1, "R4");
    tick_exp(1'b1, 16'hFFFF, 1'b1, "R4");
    set_gate(1'b0);
    set_gate(1'b1);
    tick_exp(1'b0, 16'd2, 1'b1, "R4 retrigger");
    tick_exp(1'b0, 16'd1, 1'b1, "R4");
    tick_exp(1'b1, 16'd0, 1'b1, "R4");

    // R5: rate generator, count 3, then alias code 6 with count 2
    wr(3'd2, 1'b0, 16'd3);
    tick_exp(1'b1, 16'd3, 1'b1, "R5");
    tick_exp(1'b1, 16'd2, 1'b1, "R5");
    tick_exp(1'b0, 16'd1, 1'b1, "R5");
    tick_exp(1'b1, 16'd3, 1'b1, "R5");
    tick_exp(1'b1, 16'd2, 1'b1, "R5");
    tick_exp(1'b0, 16'd1, 1'b1, "R5");
    tick_exp(1'b1, 16'd3, 1'b1, "R5");
    wr(3'd6, 1'b0, 16'd2);
    tick_exp(1'b1, 16'd2, 1'b1, "R5 alias");
    tick_exp(1'b0, 16'd1, 1'b1, "R5 alias");
    tick_exp(1'b1, 16'd2, 1'b1, "R5 alias");
    tick_exp(1'b0, 16'd1, 1'b1, "R5 alias");

    // R6: square wave, odd count 5 (3 high, 2 low)
    wr(3'd3, 1'b0, 16'd5);
    tick_exp(1'b1, 16'd4, 1'b1, "R6");
    tick_exp(1'b1, 16'd4, 1'b1, "R6");
    tick_exp(1'b1, 16'd2, 1'b1, "R6");
    tick_exp(1'b0, 16'd4, 1'b1, "R6");
    tick_exp(1'b0, 16'd2, 1'b1, "R6");
    tick_exp(1'b1, 16'd4, 1'b1, "R6");
    tick_exp(1'b1, 16'd4, 1'b1, "R6");

    // R6/R7: square wave, count 4, gate low during low phase
    wr(3'd3, 1'b0, 16'd4);
    tick_exp(1'b1, 16'd4, 1'b1, "R6");
    tick_exp(1'b1, 16'd2, 1'b1, "R6");
    tick_exp(1'b0, 16'd4, 1'b1, "R6");
    gate_in = 1'b0;
    #1;
    chk({15'd0, out_pin}, 16'd1, "R7 forced high");
    @(negedge clk);
    @(negedge clk);
    tick_exp(1'b1, 16'd4, 1'b1, "R7 frozen");
    set_gate(1'b1);
    tick_exp(1'b1, 16'd4, 1'b1, "R7 restart");
    tick_exp(1'b1, 16'd2, 1'b1, "R7");
    tick_exp(1'b0, 16'd4, 1'b1, "R7");

    // R8: software-started strobe, count 2
    wr(3'd4, 1'b0, 16'd2);
    chk({15'd0, out_pin}, 16'd1, "R8 out after write");
    tick_exp(1'b1, 16'd2, 1'b1, "R8");
    tick_exp(1'b1, 16'd1, 1'b1, "R8");
    tick_exp(1'b0, 16'd0, 1'b1, "R8 pulse");
    tick_exp(1'b1, 16'hFFFF, 1'b1, "R8");
    tick_exp(1'b1, 16'hFFFE, 1'b1, "R8");

    // R9: gate-started strobe, count 3
    set_gate(1'b0);
    wr(3'd5, 1'b0, 16'd3);
    tick_exp(1'b1, 16'd0, 1'b0, "R9 waiting");
    set_gate(1'b1);
    tick_exp(1'b1, 16'd3, 1'b1, "R9");
    tick_exp(1'b1, 16'd2, 1'b1, "R9");
    tick_exp(1'b1, 16'd1, 1'b1, "R9");
    tick_exp(1'b0, 16'd0, 1'b1, "R9 pulse");
    tick_exp(1'b1, 16'hFFFF, 1'b1, "R9");

    // R11: decimal wrap and digit borrow
    wr(3'd0, 1'b1, 16'h0002);
    tick_exp(1'b0, 16'h0002, 1'b1, "R11");
    tick_exp(1'b0, 16'h0001, 1'b1, "R11");
    tick_exp(1'b1, 16'h0000, 1'b1, "R11");
    tick_exp(1'b1, 16'h9999, 1'b1, "R11 wrap");
    tick_exp(1'b1, 16'h9998, 1'b1, "R11");
    wr(3'd0, 1'b1, 16'h0100);
    tick_exp(1'b0, 16'h0100, 1'b1, "R11");
    tick_exp(1'b0, 16'h0099, 1'b1, "R11 borrow");

    // R10: zero means full range, binary then decimal
    wr(3'd0, 1'b0, 16'd0);
    tick = 1'b1;
    repeat (65536) @(negedge clk);
    chk(count_out, 16'd1, "R10 binary count");
    chk({15'd0, out_pin}, 16'd0, "R10 binary out");
    @(negedge clk);
    chk(count_out, 16'd0, "R10 binary count");
    chk({15'd0, out_pin}, 16'd1, "R10 binary out");
    tick = 1'b0;
    @(negedge clk);
    wr(3'd0, 1'b1, 16'd0);
    tick = 1'b1;
    repeat (10000) @(negedge clk);
    chk(count_out, 16'h0001, "R10 decimal count");
    chk({15'd0, out_pin}, 16'd0, "R10 decimal out");
    @(negedge clk);
    chk(count_out, 16'h0000, "R10 decimal count");
    chk({15'd0, out_pin}, 16'd1, "R10 decimal out");
    tick = 1'b0;
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end
endmodule